// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterised set of peripheral sources and turns them into one vectored request for a processor core. Each raw request line is asynchronous to the core clock. The block synchronises each line and latches its rising edge into a single-bit pending flag per source. A flag that is already set absorbs further requests from the same source. Software gives each source an enable, a level from 0 to 7 and a sub-priority from 0 to 8.

Every cycle, the block picks the strongest pending and enabled source. The highest level wins first, then the highest sub-priority within that level, and then the lowest source index. The block presents that source only if its level is above the running 3-bit mask, or if its level is 7. The vector presented to the core is a fixed base (64 or more) plus the source index. Vector numbers with no source behind them therefore cannot appear.

When the core takes the interrupt, the block does three things. It clears that source's flag, it raises the mask to the taken level, and it reports the taken level and vector on a one-cycle strobe. A global disable input suppresses every request, level 7 included.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `ack_stb` are 0 and `mask` is 7. Every source is disabled, so a source that goes pending before it is configured is not presented.
- R2: A rising edge on `irq_raw[i]` sets pending flag i within four clock edges. A further rising edge while flag i is still set is dropped, so one acknowledge leaves no request from source i.
- R3: A pending source whose enable is 0 is never presented. Its flag is kept, and the source is presented as soon as it is enabled.
- R4: While `glb_dis` is 1, `irq_valid` is 0 for every source, including level 7.
- R5: A source of level 0 to 6 is presented only when its level is strictly greater than `mask`.
- R6: A level-7 source is presented whatever the value of `mask`.
- R7: Among presentable sources, the highest level wins. Within a level, the highest sub-priority wins; written values above 8 are treated as 8. Remaining ties go to the lowest source index.
- R8: `irq_vector` equals 64 plus the index of the presented source (parameter `VEC_BASE`, default 64), and it always lies between `VEC_BASE` and `VEC_BASE + NUM_SRC - 1`.
- R9: `ack` high while `irq_valid` is 1 takes the interrupt. At the next edge the source's flag is cleared and `mask` becomes the taken level. For exactly that one following cycle, `ack_stb` is 1 with `ack_level` and `ack_vector` holding the taken level and vector.
- R10: `ack` while `irq_valid` is 0 has no effect: no strobe appears and `mask` is unchanged.
- R11: `mask_we` loads `mask_wdata` into `mask` at the next edge, unless an acknowledge is taken in the same cycle; in that case the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_raw | input | NUM_SRC | Asynchronous peripheral request lines |
| glb_dis | input | 1 | Global interrupt disable |
| cfg_we | input | 1 | Write the configuration of one source |
| cfg_idx | input | IDX_W | Source index for the configuration write |
| cfg_en | input | 1 | Enable value written |
| cfg_level | input | 3 | Level value written |
| cfg_prio | input | 4 | Sub-priority written (above 8 clamps to 8) |
| mask_we | input | 1 | Write the running mask |
| mask_wdata | input | 3 | Mask value written |
| ack | input | 1 | Core takes the presented interrupt |
| irq_valid | output | 1 | A request is presented |
| irq_level | output | 3 | Level of the presented request |
| irq_vector | output | 8 | Vector of the presented request |
| mask | output | 3 | Current running mask |
| ack_stb | output | 1 | One-cycle strobe after a taken acknowledge |
| ack_level | output | 3 | Level taken |
| ack_vector | output | 8 | Vector taken |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before use. They also assume that `VEC_BASE` and `NUM_SRC` keep every vector within 64 to 255, and that the raw lines are free to change at any moment. The bench holds reset for several edges and keeps the default parameters. It changes control inputs only just after a rising edge. It holds each raw request high for four edges, so every synchroniser sees a clean rising edge. It drains all pending flags between scenarios, so each arbitration case starts from known pending state.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes 3-bit levels, with level 7 as the unmaskable level.
package irq_pkg;
    localparam int LVL_W     = 3;
    localparam int PRIO_W    = 4;
    localparam int PRIO_MAX  = 8;
    localparam int NMI_LEVEL = 7;
    localparam int VEC_W     = 8;

    typedef struct packed {
        logic              en;
        logic [LVL_W-1:0]  level;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;
endpackage

// File: rtl/irq_sync_edge.sv
// Synchronises each asynchronous request line with two flops and
// produces a one-cycle pulse on each synchronised rising edge.
// Assumes the request lines may change at any time.
module irq_sync_edge #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raw,
    output logic [NUM_SRC-1:0] rise
);
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_line
            logic meta_q, sync_q, prev_q;
            // Two-stage synchroniser followed by a history flop.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= raw[g];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign rise[g] = sync_q & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/irq_pending.sv
// Holds one pending flag per source. An edge pulse sets a flag and a
// clear pulse resets it; a set arriving in the same cycle wins.
// Assumes the clear vector has at most one bit set.
module irq_pending #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);
    // Latch new edges, drop serviced flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | rise;
    end

    // R2: every edge pulse leaves its flag set on the next cycle.
    a_r2_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_arbiter.sv
// Combinational arbitration. It selects the eligible source with the
// highest level, then the highest sub-priority, then the lowest index.
// Eligible means pending, enabled, not globally disabled, and with a
// level above the mask or equal to the unmaskable level.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend,
    input  src_cfg_t           cfg [NUM_SRC],
    input  logic [LVL_W-1:0]   mask,
    input  logic               glb_dis,
    output logic               sel_valid,
    output logic [IDX_W-1:0]   sel_idx,
    output logic [LVL_W-1:0]   sel_level
);
    localparam int KEY_W = LVL_W + PRIO_W;

    logic [KEY_W-1:0] best_key;

    // Scan in ascending index order; a strict compare keeps the lowest index on ties.
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        sel_level = '0;
        best_key  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && cfg[i].en && !glb_dis &&
                (cfg[i].level == LVL_W'(NMI_LEVEL) || cfg[i].level > mask)) begin
                if (!sel_valid || {cfg[i].level, cfg[i].prio} > best_key) begin
                    sel_valid = 1'b1;
                    sel_idx   = IDX_W'(i);
                    sel_level = cfg[i].level;
                    best_key  = {cfg[i].level, cfg[i].prio};
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the prioritised vectored interrupt controller. It holds the
// per-source configuration and the running mask, presents the winning
// request as a vector, and handles the acknowledge from the core.
// Assumes VEC_BASE >= 64 and VEC_BASE + NUM_SRC <= 256.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_BASE = 64,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_raw,
    input  logic               glb_dis,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_en,
    input  logic [2:0]         cfg_level,
    input  logic [3:0]         cfg_prio,
    input  logic               mask_we,
    input  logic [2:0]         mask_wdata,
    input  logic               ack,
    output logic               irq_valid,
    output logic [2:0]         irq_level,
    output logic [7:0]         irq_vector,
    output logic [2:0]         mask,
    output logic               ack_stb,
    output logic [2:0]         ack_level,
    output logic [7:0]         ack_vector
);
    localparam logic [VEC_W-1:0] VBASE = VEC_W'(VEC_BASE);
    localparam logic [VEC_W-1:0] VLAST = VEC_W'(VEC_BASE + NUM_SRC - 1);

    src_cfg_t           cfg_q [NUM_SRC];
    logic [NUM_SRC-1:0] rise, pend, clr;
    logic               sel_valid, take;
    logic [IDX_W-1:0]   sel_idx;
    logic [LVL_W-1:0]   sel_level;
    logic [PRIO_W-1:0]  prio_clamped;

    irq_sync_edge #(.NUM_SRC(NUM_SRC)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw(irq_raw), .rise(rise)
    );

    irq_pending #(.NUM_SRC(NUM_SRC)) i_pend (
        .clk(clk), .rst_n(rst_n), .rise(rise), .clr(clr), .pend(pend)
    );

    irq_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_arb (
        .pend(pend), .cfg(cfg_q), .mask(mask), .glb_dis(glb_dis),
        .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_level(sel_level)
    );

    assign irq_valid    = sel_valid;
    assign irq_level    = sel_level;
    assign irq_vector   = VBASE + VEC_W'(sel_idx);
    assign take         = ack & sel_valid;
    assign prio_clamped = (cfg_prio > PRIO_W'(PRIO_MAX)) ? PRIO_W'(PRIO_MAX) : cfg_prio;

    // Clear pulse for the source being taken.
    always_comb begin
        clr = '0;
        if (take) clr[sel_idx] = 1'b1;
    end

    // Per-source configuration registers, written one source at a time.
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[g] <= '0;
                else if (cfg_we && cfg_idx == IDX_W'(g))
                    cfg_q[g] <= '{en: cfg_en, level: cfg_level, prio: prio_clamped};
            end
        end
    endgenerate

    // Running mask: an acknowledge raises it, otherwise the core may write it.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 3'd7;
        else if (take)    mask <= sel_level;
        else if (mask_we) mask <= mask_wdata;
    end

    // One-cycle acknowledge report carrying the taken level and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_stb    <= 1'b0;
            ack_level  <= '0;
            ack_vector <= '0;
        end else begin
            ack_stb <= take;
            if (take) begin
                ack_level  <= sel_level;
                ack_vector <= irq_vector;
            end
        end
    end

    // R4: global disable silences every source.
    a_r4_global_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        glb_dis |-> !irq_valid);
    // R5 and R6: presented level is above the mask or unmaskable.
    a_r5_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level == 3'd7 || irq_level > mask));
    // R8: presented vectors stay within the mapped window.
    a_r8_vector_window: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector >= VBASE && irq_vector <= VLAST));
    // R9: a taken acknowledge raises the mask and reports what was taken.
    a_r9_ack_report: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_valid) |=> (ack_stb && mask == $past(irq_level) &&
                                ack_level == $past(irq_level) &&
                                ack_vector == $past(irq_vector)));
    // R10: no strobe without a taken acknowledge.
    a_r10_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq_valid) |=> !ack_stb);
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    typedef struct packed {
        logic [7:0] raise;
        logic [2:0] msk;
        logic       vld;
        logic [2:0] idx;
        logic [2:0] lvl;
    } row_t;

    // Arbitration scenarios (R5, R6, R7, R8) under a fixed configuration.
    localparam row_t ROWS [13] = '{
        '{8'h01, 3'd0, 1'b1, 3'd0, 3'd3},
        '{8'h03, 3'd0, 1'b1, 3'd1, 3'd3},
        '{8'h0A, 3'd0, 1'b1, 3'd1, 3'd3},
        '{8'h05, 3'd0, 1'b1, 3'd2, 3'd5},
        '{8'hC0, 3'd0, 1'b1, 3'd6, 3'd5},
        '{8'h80, 3'd0, 1'b1, 3'd7, 3'd5},
        '{8'h44, 3'd0, 1'b1, 3'd6, 3'd5},
        '{8'h01, 3'd3, 1'b0, 3'd0, 3'd0},
        '{8'h01, 3'd2, 1'b1, 3'd0, 3'd3},
        '{8'h10, 3'd7, 1'b1, 3'd4, 3'd7},
        '{8'h20, 3'd0, 1'b1, 3'd5, 3'd1},
        '{8'h20, 3'd1, 1'b0, 3'd0, 3'd0},
        '{8'h31, 3'd6, 1'b1, 3'd4, 3'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_raw = '0;
    logic       glb_dis = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic       cfg_en = 1'b0;
    logic [2:0] cfg_level = '0;
    logic [3:0] cfg_prio = '0;
    logic       mask_we = 1'b0;
    logic [2:0] mask_wdata = '0;
    logic       ack = 1'b0;
    logic       irq_valid, ack_stb;
    logic [2:0] irq_level, mask, ack_level;
    logic [7:0] irq_vector, ack_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .glb_dis(glb_dis),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_level(cfg_level), .cfg_prio(cfg_prio),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ack(ack),
        .irq_valid(irq_valid), .irq_level(irq_level), .irq_vector(irq_vector),
        .mask(mask), .ack_stb(ack_stb), .ack_level(ack_level), .ack_vector(ack_vector)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_mask(logic [2:0] v);
        mask_we = 1'b1; mask_wdata = v;
        tick();
        mask_we = 1'b0;
    endtask

    task automatic config_src(int idx, logic en, logic [2:0] lvl, logic [3:0] pr);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_level = lvl; cfg_prio = pr;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic raise(logic [7:0] m);
        irq_raw = m;
        repeat (4) tick();
        irq_raw = '0;
        repeat (3) tick();
    endtask

    task automatic take_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 12; k++) begin
            set_mask(3'd0);
            if (irq_valid) take_ack();
        end
        set_mask(3'd0);
    endtask

    initial begin
        repeat (4) tick();
        // R1: reset state.
        check("R1 valid", irq_valid, 0);
        check("R1 mask", mask, 7);
        check("R1 strobe", ack_stb, 0);
        rst_n = 1'b1;
        tick();
        check("R1 valid after release", irq_valid, 0);

        // R11: the mask write takes effect.
        set_mask(3'd0);
        check("R11 mask write", mask, 0);

        // R1/R3: an unconfigured source stays hidden but keeps its flag.
        raise(8'h01);
        check("R1 disabled after reset", irq_valid, 0);
        config_src(0, 1'b1, 3'd3, 4'd2);
        check("R3 held flag shown", irq_valid, 1);
        check("R8 vector src0", irq_vector, 64);

        // R9: acknowledge clears the flag, raises the mask, strobes once.
        take_ack();
        check("R9 strobe", ack_stb, 1);
        check("R9 ack level", ack_level, 3);
        check("R9 ack vector", ack_vector, 64);
        check("R9 mask raised", mask, 3);
        check("R9 valid cleared", irq_valid, 0);
        tick();
        check("R9 strobe one cycle", ack_stb, 0);

        // R10: acknowledge with nothing presented.
        take_ack();
        check("R10 no strobe", ack_stb, 0);
        check("R10 mask kept", mask, 3);

        // R3: disabling hides a pending source.
        set_mask(3'd0);
        config_src(0, 1'b0, 3'd3, 4'd2);
        raise(8'h01);
        check("R3 disabled hidden", irq_valid, 0);
        config_src(0, 1'b1, 3'd3, 4'd2);
        check("R3 enabled shown", irq_valid, 1);
        drain();

        // R2: a second request while pending is dropped.
        raise(8'h01);
        raise(8'h01);
        check("R2 pending", irq_valid, 1);
        take_ack();
        set_mask(3'd0);
        check("R2 repeat dropped", irq_valid, 0);

        // R4 and R6: global disable blocks even level 7.
        config_src(4, 1'b1, 3'd7, 4'd1);
        glb_dis = 1'b1;
        raise(8'h10);
        check("R4 blocked", irq_valid, 0);
        set_mask(3'd7);
        check("R4 blocked at mask 7", irq_valid, 0);
        glb_dis = 1'b0;
        tick();
        check("R6 level7 shown", irq_valid, 1);
        check("R6 level7 vector", irq_vector, 68);
        drain();

        // Fixed configuration for the table walk.
        config_src(1, 1'b1, 3'd3, 4'd5);
        config_src(2, 1'b1, 3'd5, 4'd0);
        config_src(3, 1'b1, 3'd3, 4'd5);
        config_src(5, 1'b1, 3'd1, 4'd8);
        config_src(6, 1'b1, 3'd5, 4'd12);
        config_src(7, 1'b1, 3'd5, 4'd8);
        drain();

        // R5 R6 R7 R8: table of arbitration scenarios.
        foreach (ROWS[r]) begin
            set_mask(ROWS[r].msk);
            raise(ROWS[r].raise);
            check($sformatf("R5/R7 row %0d valid", r), irq_valid, ROWS[r].vld);
            if (ROWS[r].vld) begin
                check($sformatf("R7/R8 row %0d vector", r), irq_vector, 64 + ROWS[r].idx);
                check($sformatf("R7 row %0d level", r), irq_level, ROWS[r].lvl);
            end
            drain();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule